// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block runs the control handshake of an external eight-input successive-approximation analog-to-digital converter on behalf of a host. The host presents a 3-bit input number together with a one-cycle request while the block shows it is ready. The block then drives the input-select lines and, in a fixed order, the select-latch strobe, the start strobe and the read enable. It follows the converter's end-of-conversion line through its fall and its return high, and reads back the 8-bit code. The code is returned with a one-cycle valid pulse and the number of the input it belongs to.

A free-running divider derives the converter's clock from the system clock. Every timed phase of the handshake lasts a parameterized number of system clocks, which covers the converter's minimum pulse widths. A watchdog ends a conversion whose end-of-conversion handshake never completes. It then flags an error and returns the block to idle. With a 5 V reference one code step is close to 19.5 mV. That scaling belongs to the consumer of the result and does not affect this logic.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `ready` is 1, `adc_ale`, `adc_start`, `adc_oe`, `res_valid`, `err_timeout` and `adc_clk` are 0.
- R2: A request is taken only while `ready` is 1, and `ready` is 0 from the cycle after acceptance until the sequence ends. A request made while `ready` is 0 has no effect: it produces no second result and does not change the channel being converted.
- R3: `adc_addr` carries the accepted channel before `adc_ale` rises and holds it unchanged while `adc_ale` or `adc_start` is high.
- R4: `adc_ale` and `adc_start` rise in the same cycle. `adc_ale` then falls while `adc_start` stays high, and only after that does `adc_start` fall.
- R5: The address setup, the combined strobe high phase, the phase with only start high, and the read phase each last exactly `HOLD_CYC` system clocks.
- R6: After `adc_start` falls the block waits for `adc_eoc` to go low and then high again. `adc_oe` does not rise before that return high.
- R7: `adc_oe` is high for `HOLD_CYC` clocks. The value on `adc_data` at the last of these clocks appears on `res_data` with a one-cycle `res_valid` pulse and `res_chan` equal to the accepted channel.
- R8: If the low-then-high end-of-conversion handshake has not completed `TIMEOUT_CYC` clocks after `adc_start` falls, the block returns to idle with `ready` 1 exactly `TIMEOUT_CYC` clocks after that fall. `err_timeout` is then 1 and no `res_valid` pulse occurs. `err_timeout` clears when the next request is accepted.
- R9: `adc_clk` toggles every `CLK_HALF` system clocks, which gives a period of 2*`CLK_HALF` clocks.
- R10: `adc_oe` is never high in a cycle where `adc_ale` or `adc_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request, taken when `ready` is 1 |
| req_chan | input | 3 | Analog input number for the request |
| ready | output | 1 | Idle and able to take a request |
| adc_addr | output | 3 | Input-select lines to the converter |
| adc_ale | output | 1 | Select-latch strobe, latched on its rising edge |
| adc_start | output | 1 | Start strobe: rise clears, fall starts conversion |
| adc_oe | output | 1 | Read enable for the converter's data bus |
| adc_clk | output | 1 | Divided clock for the converter |
| adc_eoc | input | 1 | End of conversion, low while converting |
| adc_data | input | 8 | Converter output code |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 8 | Captured conversion code |
| res_chan | output | 3 | Channel the result belongs to |
| err_timeout | output | 1 | Last conversion was abandoned by the watchdog |

## Verification
The assertions assume that `adc_eoc` comes from a converter that only drops it after a start fall and raises it again later, and that `adc_data` is steady while `adc_oe` is high. The bench responder is a converter model that holds to this. It drops end-of-conversion three clocks after the start fall and restores it after a fixed conversion time. It drives the code only while the read enable is high and forces the line high again on every new start rise. For the timeout cases the responder is switched to leave end-of-conversion stuck high or stuck low, and those are the only departures from the converter's normal behaviour.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_ARM   = 3'd2,
    ST_LATCH = 3'd3,
    ST_WFALL = 3'd4,
    ST_WRISE = 3'd5,
    ST_READ  = 3'd6
  } seq_state_t;
endpackage

// File: rtl/adc_clkgen.sv
module adc_clkgen #(
  parameter int CLK_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  output logic adc_clk
);
  localparam int CW = $clog2(CLK_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      adc_clk <= 1'b0;
    end else if (cnt == LAST) begin
      cnt     <= '0;
      adc_clk <= ~adc_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: the divided clock never toggles two cycles running when the half period exceeds one
  p_clk_no_glitch_r9: assert property (@(posedge clk) disable iff (rst)
    (CLK_HALF > 1 && $changed(adc_clk)) |=> $stable(adc_clk));
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W      = 3,
  parameter int DATA_W      = 8,
  parameter int HOLD_CYC    = 3,
  parameter int CLK_HALF    = 4,
  parameter int TIMEOUT_CYC = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CHAN_W-1:0] req_chan,
  output logic              ready,
  output logic [CHAN_W-1:0] adc_addr,
  output logic              adc_ale,
  output logic              adc_start,
  output logic              adc_oe,
  output logic              adc_clk,
  input  logic              adc_eoc,
  input  logic [DATA_W-1:0] adc_data,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CHAN_W-1:0] res_chan,
  output logic              err_timeout
);
  seq_state_t state, nxt;
  logic [1:0] eoc_sync;
  logic       eoc_s;
  logic       timed, waiting, hold_done, wd_expire, accept;

  assign eoc_s   = eoc_sync[1];
  assign accept  = (state == ST_IDLE) && req_valid;
  assign timed   = (state == ST_SETUP) || (state == ST_ARM) ||
                   (state == ST_LATCH) || (state == ST_READ);
  assign waiting = (state == ST_WFALL) || (state == ST_WRISE);

  adc_clkgen #(.CLK_HALF(CLK_HALF)) u_clk (
    .clk(clk), .rst(rst), .adc_clk(adc_clk)
  );

  adc_phase_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .run(timed), .done(hold_done)
  );

  adc_phase_timer #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk(clk), .rst(rst), .run(waiting), .done(wd_expire)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (req_valid) nxt = ST_SETUP;
      ST_SETUP: if (hold_done) nxt = ST_ARM;
      ST_ARM:   if (hold_done) nxt = ST_LATCH;
      ST_LATCH: if (hold_done) nxt = ST_WFALL;
      ST_WFALL: if (wd_expire) nxt = ST_IDLE;
                else if (!eoc_s) nxt = ST_WRISE;
      ST_WRISE: if (wd_expire) nxt = ST_IDLE;
                else if (eoc_s) nxt = ST_READ;
      ST_READ:  if (hold_done) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      eoc_sync    <= 2'b11;
      ready       <= 1'b1;
      adc_addr    <= '0;
      adc_ale     <= 1'b0;
      adc_start   <= 1'b0;
      adc_oe      <= 1'b0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_chan    <= '0;
      err_timeout <= 1'b0;
    end else begin
      state     <= nxt;
      eoc_sync  <= {eoc_sync[0], adc_eoc};
      ready     <= (nxt == ST_IDLE);
      adc_ale   <= (nxt == ST_ARM);
      adc_start <= (nxt == ST_ARM) || (nxt == ST_LATCH);
      adc_oe    <= (nxt == ST_READ);
      res_valid <= (state == ST_READ) && hold_done;
      if (accept) begin
        adc_addr    <= req_chan;
        err_timeout <= 1'b0;
      end else if (waiting && wd_expire) begin
        err_timeout <= 1'b1;
      end
      if ((state == ST_READ) && hold_done) begin
        res_data <= adc_data;
        res_chan <= adc_addr;
      end
    end
  end

  // R4: latch strobe and start strobe rise together
  p_strobes_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_ale) |-> $rose(adc_start));
  // R4: start falls only after the latch strobe is already low
  p_start_fall_late_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_start) |-> !$past(adc_ale));
  // R3: the select lines hold while either strobe is high
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (adc_ale || adc_start) |-> $stable(adc_addr));
  // R10: read enable never overlaps the strobes
  p_oe_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    adc_oe |-> (!adc_ale && !adc_start));
  // R7: the result strobe lasts one cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R2: a sequence never starts while the block claims to be idle
  p_busy_on_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_ale) |-> !ready);
  // R8: an abort never comes with a result
  p_abort_no_result_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_timeout) |-> (!res_valid && ready));
  // R6: read enable rises only after end-of-conversion has been high
  p_oe_after_eoc_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_oe) |-> $past(eoc_s));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int HOLD    = 3;
  localparam int HALF    = 4;
  localparam int TMO     = 400;
  localparam int CONV    = 20;
  localparam int WDOG_NS = 150000 * 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_chan = '0;
  logic       ready, adc_ale, adc_start, adc_oe, adc_clk;
  logic [2:0] adc_addr, res_chan;
  logic       adc_eoc = 1'b1;
  logic [7:0] adc_data = '0;
  logic       res_valid, err_timeout;
  logic [7:0] res_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] seed = 8'h00;
  int mode = 0;
  logic mon_clr = 1'b0;

  // monitor / responder state, written only by the responder process
  logic       p_ale = 0, p_start = 0, busy = 0;
  logic [2:0] lat_ch = '0;
  int cyc = 0, ale_cnt = 0, ale_w = 0, gap_cnt = 0, gap_w = 0, oe_cnt = 0, oe_w = 0;
  int nres = 0, rise_bad = 0, oe_early = 0, overlap = 0, addr_bad = 0;
  logic [7:0] last_data = '0;
  logic [2:0] last_chan = '0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.CHAN_W(3), .DATA_W(8), .HOLD_CYC(HOLD), .CLK_HALF(HALF),
                 .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .ready(ready), .adc_addr(adc_addr), .adc_ale(adc_ale), .adc_start(adc_start),
    .adc_oe(adc_oe), .adc_clk(adc_clk), .adc_eoc(adc_eoc), .adc_data(adc_data),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .err_timeout(err_timeout)
  );

  function automatic logic [7:0] code_of(input logic [2:0] ch, input logic [7:0] s);
    return (8'(ch) * 8'd29 + 8'd7) ^ s;
  endfunction

  // behavioural converter and pin monitor
  always @(negedge clk) begin
    if (mon_clr) begin
      nres = 0; rise_bad = 0; oe_early = 0; overlap = 0; addr_bad = 0;
      ale_w = 0; gap_w = 0; oe_w = 0;
    end
    if (adc_ale && !p_ale) begin
      lat_ch = adc_addr;
      if (!(adc_start && !p_start)) rise_bad++;
      adc_eoc <= 1'b1; busy = 0; ale_cnt = 0;
    end
    if (adc_ale) ale_cnt++;
    if (!adc_ale && p_ale) begin ale_w = ale_cnt; gap_cnt = 0; end
    if (!adc_ale && adc_start) gap_cnt++;
    if ((adc_ale || adc_start) && adc_addr != lat_ch) addr_bad++;
    if (!adc_start && p_start) begin gap_w = gap_cnt; busy = 1; cyc = 0; end
    else if (busy) begin
      cyc++;
      if (cyc == 3 && mode != 1) adc_eoc <= 1'b0;
      if (cyc == 3 + CONV && mode == 0) begin adc_eoc <= 1'b1; busy = 0; end
    end
    if (adc_oe && (busy || !adc_eoc)) oe_early++;
    if (adc_oe && (adc_ale || adc_start)) overlap++;
    if (adc_oe) oe_cnt++;
    else if (oe_cnt != 0) begin oe_w = oe_cnt; oe_cnt = 0; end
    adc_data <= adc_oe ? code_of(lat_ch, seed) : 8'h00;
    if (res_valid) begin nres++; last_data = res_data; last_chan = res_chan; end
    p_ale = adc_ale; p_start = adc_start;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic issue(input logic [2:0] ch);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_chan = ch;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ready && n < 3000);
  endtask

  task automatic t_reset();
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk({adc_ale, adc_start, adc_oe} == 3'b000, "R1 strobes", {adc_ale, adc_start, adc_oe}, 0);
    chk(res_valid == 1'b0 && err_timeout == 1'b0, "R1 result flags", {res_valid, err_timeout}, 0);
    chk(adc_clk == 1'b0, "R1 adc_clk", adc_clk, 0);
  endtask

  task automatic t_convert(input logic [2:0] ch, input logic [7:0] s);
    int n;
    seed = s;
    clear_mon();
    issue(ch);
    chk(ready == 1'b0, "R2 busy after accept", ready, 0);
    wait_idle(n);
    repeat (3) @(negedge clk);
    chk(nres == 1, "R7 one result", nres, 1);
    chk(last_data == code_of(ch, s), "R7 result data", last_data, code_of(ch, s));
    chk(last_chan == ch, "R7 result chan", last_chan, ch);
    chk(lat_ch == ch && addr_bad == 0, "R3 latched address", lat_ch, ch);
    chk(rise_bad == 0, "R4 joint rise", rise_bad, 0);
    chk(ale_w == HOLD && gap_w == HOLD, "R5 strobe phase widths", ale_w * 100 + gap_w, HOLD * 101);
    chk(oe_w == HOLD, "R5 R7 read width", oe_w, HOLD);
    chk(oe_early == 0, "R6 oe after eoc return", oe_early, 0);
    chk(overlap == 0, "R10 oe exclusive", overlap, 0);
    chk(err_timeout == 1'b0, "R8 no error on good run", err_timeout, 0);
  endtask

  task automatic t_busy_ignored();
    int n;
    seed = 8'h5A;
    clear_mon();
    issue(3'd2);
    repeat (4) @(negedge clk);
    req_valid = 1'b1; req_chan = 3'd5;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (HOLD * 3 + 5) @(negedge clk);
    req_valid = 1'b1; req_chan = 3'd6;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle(n);
    repeat (20) @(negedge clk);
    chk(nres == 1, "R2 busy request ignored count", nres, 1);
    chk(last_chan == 3'd2 && lat_ch == 3'd2, "R2 busy request chan", last_chan, 2);
    chk(last_data == code_of(3'd2, 8'h5A), "R2 busy request data", last_data, code_of(3'd2, 8'h5A));
  endtask

  task automatic t_timeout(input int m);
    int n;
    mode = m;
    clear_mon();
    issue(3'd4);
    while (!(p_start && !adc_start)) @(negedge clk);
    wait_idle(n);
    chk(n == TMO, "R8 abort delay", n, TMO);
    chk(err_timeout == 1'b1, "R8 error flag", err_timeout, 1);
    repeat (5) @(negedge clk);
    chk(nres == 0 && oe_w == 0, "R8 no read on abort", nres + oe_w, 0);
    mode = 0;
    t_convert(3'd1, 8'h33);
  endtask

  task automatic t_clkdiv();
    logic prev;
    int n;
    prev = adc_clk;
    while (adc_clk == prev) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      prev = adc_clk; n = 0;
      while (adc_clk == prev && n < 100) begin @(negedge clk); n++; end
      chk(n == HALF, "R9 adc_clk half period", n, HALF);
    end
  endtask

  initial begin
    #(WDOG_NS);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clkdiv();
    for (int c = 0; c < 8; c++) t_convert(3'(c), 8'(c * 17));
    t_convert(3'd7, 8'hFF);
    t_busy_ignored();
    t_timeout(1);
    t_timeout(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule